// File: doc/BRIEF.md
# Iterative 64-bit Lightweight Block Cipher Encryption Core

This core encrypts one 64-bit block under an 80-bit key. It completes one full cipher round every clock cycle. A one-cycle start strobe, accepted only while the core is idle, captures the plaintext and the key into internal state and key registers. The core then runs 31 rounds. In each round the 64 most significant key register bits are XORed into the state, every nibble of the state goes through a 4-bit substitution, and the bits are then permuted. The key register is updated alongside each round. After the last round, one more round-key XOR produces the ciphertext. The core raises done for one cycle, and the ciphertext output keeps its value until the next block finishes.

The 4-bit substitution is built from four 4:1 multiplexers, one for each output bit. Input bits 1:0 drive the select of every multiplexer. The data legs are small functions of input bits 3:2. The key update uses one more instance of the same substitution on its top nibble.

Top module: `lwc_core`

## Requirements
- R1: While the synchronous active-high reset is applied, and on the first cycle after it, busy and done are 0 and ciphertext is all zeros.
- R2: A start pulse sampled while busy is 0 loads plaintext and key, and busy reads 1 from the next cycle.
- R3: Done is high for exactly one cycle. It appears 32 cycles after the clock edge that accepted start. Busy reads 0 from that same cycle.
- R4: The ciphertext equals 31 rounds of (round-key XOR, substitution layer, permutation layer) followed by one final round-key XOR. The round key is key register bits 79:16. The all-zero key with the all-zero plaintext gives 5579C1387B228445. The all-ones key with the all-ones plaintext gives 3333DCD3213210D2.
- R5: The substitution maps nibble values 0 to F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. It is applied to all sixteen nibbles of the state.
- R6: The permutation moves state bit i to bit (16*i) mod 63 for i from 0 to 62. Bit 63 does not move.
- R7: On each round the key register is rotated left by 61 positions. Its bits 79:76 are then replaced by their substitution, and bits 19:15 are XORed with the round number. The round number runs from 1 to 31.
- R8: A start pulse that arrives while busy is 1 is ignored. The running block completes with unchanged ciphertext and latency.
- R9: The ciphertext output holds its value in every cycle in which done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin encryption of plaintext under key (taken only when idle) |
| plaintext | input | 64 | Block to encrypt |
| key | input | 80 | Cipher key |
| ciphertext | output | 64 | Result, held until the next completion |
| busy | output | 1 | High from the cycle after acceptance until done |
| done | output | 1 | One-cycle pulse when the ciphertext is valid |

## Verification
The bench builds the core with its default of 31 rounds. At that setting the two known-answer blocks, all zeros and all ones, can be checked against their published ciphertexts. A bench-side model then computes the expected ciphertext for a sweep of pseudo-random blocks and keys. The model uses a table substitution and an arithmetic permutation, so every multiplexer leg of the substitution, every permutation wire and every key-schedule step is exercised on the full-length datapath. A start pulse in the middle of a run and repeated back-to-back blocks cover the ignore rule and the output hold.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    localparam int BLK_W     = 64;
    localparam int KEY_W     = 80;
    localparam int NIB_W     = 4;
    localparam int NIBBLES   = BLK_W / NIB_W;
    localparam int KEY_ROT   = 61;
    localparam int RCON_W    = 5;
    localparam int RCON_LSB  = 15;
    localparam int PERM_MUL  = BLK_W / NIB_W;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [KEY_W-1:0] key_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ROUND = 2'd1,
        PH_FINAL = 2'd2
    } phase_e;

    function automatic blk_t round_key(input key_t k);
        return k[KEY_W-1 -: BLK_W];
    endfunction
endpackage

// File: rtl/lwc_sbox4.sv
module lwc_sbox4
    import lwc_pkg::*;
(
    input  nib_t x,
    output nib_t y
);
    logic hi, lo;
    logic [1:0] sel;
    // one 4-leg multiplexer per output bit, legs indexed by the select value
    logic [3:0] leg0, leg1, leg2, leg3;

    assign hi  = x[3];
    assign lo  = x[2];
    assign sel = x[1:0];

    assign leg0 = {~hi,            hi,             ~(hi ^ lo),     hi ^ lo};
    assign leg1 = {~(hi ^ lo),     ~(hi & lo),     hi,             hi & ~lo};
    assign leg2 = {~hi & lo,       ~lo,            ~lo | hi,       ~(hi ^ lo)};
    assign leg3 = {~(hi & lo),     hi ^ lo,        hi & ~lo,       ~hi};

    assign y = {leg3[sel], leg2[sel], leg1[sel], leg0[sel]};
endmodule

// File: rtl/lwc_sub_layer.sv
module lwc_sub_layer
    import lwc_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
        lwc_sbox4 u_sb (
            .x (din[n*NIB_W +: NIB_W]),
            .y (dout[n*NIB_W +: NIB_W])
        );
    end
endmodule

// File: rtl/lwc_perm_layer.sv
module lwc_perm_layer
    import lwc_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    for (genvar i = 0; i < BLK_W - 1; i++) begin : g_bit
        assign dout[(i * PERM_MUL) % (BLK_W - 1)] = din[i];
    end
    assign dout[BLK_W-1] = din[BLK_W-1];
endmodule

// File: rtl/lwc_key_sched.sv
module lwc_key_sched
    import lwc_pkg::*;
(
    input  key_t              kin,
    input  logic [RCON_W-1:0] rc,
    output key_t              kout
);
    key_t rot;
    nib_t top_sub;

    assign rot = {kin[KEY_W-1-KEY_ROT:0], kin[KEY_W-1:KEY_W-KEY_ROT]};

    lwc_sbox4 u_top_sb (
        .x (rot[KEY_W-1 -: NIB_W]),
        .y (top_sub)
    );

    always_comb begin
        kout = rot;
        kout[KEY_W-1 -: NIB_W] = top_sub;
        kout[RCON_LSB +: RCON_W] = rot[RCON_LSB +: RCON_W] ^ rc;
    end
endmodule

// File: rtl/lwc_core.sv
module lwc_core
    import lwc_pkg::*;
#(
    parameter int ROUNDS = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] plaintext,
    input  logic [KEY_W-1:0] key,
    output logic [BLK_W-1:0] ciphertext,
    output logic             busy,
    output logic             done
);
    localparam logic [RCON_W-1:0] LAST_RND = RCON_W'(ROUNDS);

    phase_e            phase_q;
    blk_t              state_q;
    key_t              key_q;
    logic [RCON_W-1:0] rnd_q;

    blk_t mixed, sub_out, perm_out;
    key_t key_nx;

    assign mixed = state_q ^ round_key(key_q);

    lwc_sub_layer u_sub (
        .din  (mixed),
        .dout (sub_out)
    );

    lwc_perm_layer u_perm (
        .din  (sub_out),
        .dout (perm_out)
    );

    lwc_key_sched u_ks (
        .kin  (key_q),
        .rc   (rnd_q),
        .kout (key_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            state_q    <= '0;
            key_q      <= '0;
            rnd_q      <= '0;
            ciphertext <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        state_q <= plaintext;
                        key_q   <= key;
                        rnd_q   <= RCON_W'(1);
                        phase_q <= PH_ROUND;
                    end
                end
                PH_ROUND: begin
                    state_q <= perm_out;
                    key_q   <= key_nx;
                    rnd_q   <= rnd_q + 1'b1;
                    if (rnd_q == LAST_RND) begin
                        phase_q <= PH_FINAL;
                    end
                end
                PH_FINAL: begin
                    ciphertext <= mixed;
                    done       <= 1'b1;
                    phase_q    <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/lwc_core_chk.sv
module lwc_core_chk
    import lwc_pkg::*;
#(
    parameter int ROUNDS = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [BLK_W-1:0] ciphertext,
    input logic             busy,
    input logic             done
);
    localparam int CNT_W = $clog2(ROUNDS + 4) + 1;
    logic [CNT_W-1:0] since_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_go <= '0;
        end else if (start && !busy) begin
            since_go <= CNT_W'(1);
        end else if (busy) begin
            since_go <= since_go + 1'b1;
        end
    end

    // R2: accepted start raises busy next cycle
    p_load_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: done lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: busy only drops together with done
    p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3 and R8: done exactly one block latency after the accepting edge, not restarted
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_go == CNT_W'(ROUNDS + 2)));

    // R9: result stable between completions
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ciphertext));
endmodule

bind lwc_core lwc_core_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ciphertext (ciphertext),
    .busy       (busy),
    .done       (done)
);

// File: tb/lwc_core_bench.sv
module lwc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] plaintext = '0;
    logic [79:0] key = '0;
    logic [63:0] ciphertext;
    logic        busy, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    lwc_core u_lwc_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plaintext  (plaintext),
        .key        (key),
        .ciphertext (ciphertext),
        .busy       (busy),
        .done       (done)
    );

    function automatic logic [3:0] ref_sb(input logic [3:0] x);
        case (x)
            4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
            4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
            4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
            4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
        endcase
    endfunction

    function automatic logic [63:0] ref_round(input logic [63:0] s);
        logic [63:0] t, p;
        for (int n = 0; n < 16; n++) t[n*4 +: 4] = ref_sb(s[n*4 +: 4]);
        p = '0;
        for (int i = 0; i < 63; i++) p[(16 * i) % 63] = t[i];
        p[63] = t[63];
        return p;
    endfunction

    function automatic logic [63:0] ref_encrypt(input logic [63:0] pt, input logic [79:0] k);
        logic [63:0] s;
        logic [79:0] kk;
        s  = pt;
        kk = k;
        for (int r = 1; r <= 31; r++) begin
            s  = ref_round(s ^ kk[79:16]);
            kk = {kk[18:0], kk[79:19]};
            kk[79:76] = ref_sb(kk[79:76]);
            kk[19:15] = kk[19:15] ^ 5'(r);
        end
        return s ^ kk[79:16];
    endfunction

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_block(input logic [63:0] pt, input logic [79:0] k,
                             input logic [63:0] exp_ct, input bit poke, input string req);
        int cyc;
        @(negedge clk);
        plaintext = pt;
        key       = k;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after accept", 80'(busy), 80'(1));
        cyc = 0;
        while (done !== 1'b1 && cyc < 200) begin
            if (poke && cyc == 10) begin
                plaintext = ~pt;
                key       = ~k;
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == 32, "R3 latency", 80'(cyc), 80'(32));
        check(busy === 1'b0, "R3 busy low with done", 80'(busy), 80'(0));
        check(ciphertext === exp_ct, req, 80'(ciphertext), 80'(exp_ct));
        @(negedge clk);
        check(done === 1'b0, "R3 done single cycle", 80'(done), 80'(0));
        check(ciphertext === exp_ct, "R9 hold after done", 80'(ciphertext), 80'(exp_ct));
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] xs;
        logic [63:0] pt;
        logic [79:0] k;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ciphertext === '0, "R1 reset state",
              {14'(0), busy, done, ciphertext}, 80'(0));
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && ciphertext === '0, "R1 after reset",
              {14'(0), busy, done, ciphertext}, 80'(0));

        // R4 known answers
        run_block(64'h0, 80'h0, 64'h5579C1387B228445, 1'b0, "R4 all-zero known answer");
        run_block(64'hFFFF_FFFF_FFFF_FFFF, {80{1'b1}}, 64'h3333DCD3213210D2, 1'b0,
                  "R4 all-ones known answer");

        // R8 start during a run is ignored
        run_block(64'h0123_4567_89AB_CDEF, 80'h1234_5678_9ABC_DEF0_1357,
                  ref_encrypt(64'h0123_4567_89AB_CDEF, 80'h1234_5678_9ABC_DEF0_1357), 1'b1,
                  "R8 mid-run start ignored");

        // R5 R6 R7 sweep of single-bit and pseudo-random patterns
        for (int b = 0; b < 64; b += 7) begin
            pt = 64'(1) << b;
            k  = 80'(1) << (b + 13);
            run_block(pt, k, ref_encrypt(pt, k), 1'b0, "R5 R6 R7 single-bit sweep");
        end
        xs = 64'h9E37_79B9_7F4A_7C15;
        for (int v = 0; v < 40; v++) begin
            xs = xs ^ (xs << 13); xs = xs ^ (xs >> 7); xs = xs ^ (xs << 17);
            pt = xs;
            xs = xs ^ (xs << 13); xs = xs ^ (xs >> 7); xs = xs ^ (xs << 17);
            k  = {xs[15:0], xs};
            run_block(pt, k, ref_encrypt(pt, k), (v % 5) == 2, "R4 R5 R6 R7 random block");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule